// File: doc/BRIEF.md
# TDM Time Slot Assigner

This block connects one serial link channel to a shared time-division multiplexed bus. The bus carries a bit clock, a frame sync, a receive data line and a transmit data line. The block counts bit times from each frame sync. It opens a window that covers a programmed, contiguous range of bit positions in the frame. Inside that window it forwards each received bit to the channel with a one-cycle valid strobe, and it drives the channel's transmit bits onto the bus. Outside the window it releases the transmit line, so other channels can use the same bus.

The window bounds are bit-granular 12-bit positions counted from frame sync. The window can therefore cover a whole frame of up to 4096 bits, a run of whole 8-bit slots (up to 512 of them), or only a few bits of one slot. Selecting part of a slot is useful for signalling sub-channels. The bus signals are synchronised into the system clock domain, and the bit clock edges are found there. Bounds presented on the configuration inputs are captured only when a frame sync is seen. A change made in the middle of a frame therefore takes effect from the following frame.

Top module: `tdm_slot_assigner`

## Requirements
- R1: While reset is held and right after it is released, `tdm_txd_oe`, `tdm_txd`, `ch_rx_valid` and `ch_tx_take` are all 0.
- R2: On a bit clock rising edge where frame sync is high, the bit position becomes 0. On every other rising edge it advances by one, wrapping from 4095 to 0.
- R3: A bit is inside the window when start <= position <= stop, with both bounds inclusive. `tdm_txd_oe` is 1 for exactly the bits inside the window.
- R4: When start is greater than stop, no bit of the frame is inside the window: there is no transmit enable, no take and no receive strobe.
- R5: For each bit inside the window, the bus receive line is sampled at the bit clock falling edge. That value appears on `ch_rx_bit` with exactly one single-cycle pulse of `ch_rx_valid`. Bits outside the window produce no pulse.
- R6: At the rising edge that starts a bit inside the window, `tdm_txd` takes the value of `ch_tx_bit`, and `ch_tx_take` pulses once so the channel advances to its next bit. Outside the window `tdm_txd` is 0 and no take pulse occurs.
- R7: Bounds on `cfg_start`/`cfg_stop` are captured only at a frame sync. A change made in the middle of a frame does not alter the window of that frame.
- R8: Until the first frame sync after reset, the window is never open.
- R9: The bounds cover the full 12-bit range. A window of 0..4095 covers every bit of a frame, and a window of 4095..4095 selects only the last bit of a 4096-bit frame.
- R10: A window of a single bit (start equal to stop) opens for exactly one bit per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tdm_bclk | input | 1 | Bus bit clock (asynchronous, slower than clk) |
| tdm_fsync | input | 1 | Bus frame sync, sampled at the bit clock rising edge |
| tdm_rxd | input | 1 | Bus receive data, sampled at the bit clock falling edge |
| tdm_txd | output | 1 | Bus transmit data |
| tdm_txd_oe | output | 1 | Transmit enable for the bus pad; 0 leaves the line released |
| cfg_start | input | 12 | First bit position of the window |
| cfg_stop | input | 12 | Last bit position of the window |
| ch_rx_bit | output | 1 | Received bit forwarded to the channel |
| ch_rx_valid | output | 1 | One-cycle strobe that qualifies `ch_rx_bit` |
| ch_tx_bit | input | 1 | Next transmit bit offered by the channel |
| ch_tx_take | output | 1 | One-cycle pulse: `ch_tx_bit` was consumed |

## Verification
The bench builds the block with its defaults: a 12-bit position counter and a two-stage synchroniser. Each bus bit lasts fourteen system clocks, which leaves room for the synchroniser and the output registers. The full 12-bit counter is kept, so one 4097-bit frame reaches the position 4095 boundary and the wrap back to 0. The remaining frames are short, so many random windows fit in the run; these include empty windows, windows with reversed bounds and bound changes in the middle of a frame.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  parameter int unsigned TSA_POS_W = 12;
  typedef logic [TSA_POS_W-1:0] bitpos_t;

  typedef struct packed {
    bitpos_t pos;
    bitpos_t lo;
    bitpos_t hi;
    logic    armed;
  } win_state_t;

  function automatic logic in_window(win_state_t s);
    return s.armed && (s.pos >= s.lo) && (s.pos <= s.hi);
  endfunction
endpackage

// File: rtl/tsa_edge_sync.sv
module tsa_edge_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         rise,
  output logic         fall
);
  logic [W-1:0] pipe [STAGES];
  logic         edge_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
      edge_d <= 1'b0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
      edge_d <= pipe[STAGES-1][0];
    end
  end

  assign dout = pipe[STAGES-1];
  // bit 0 carries the bit clock
  assign rise = dout[0] & ~edge_d;
  assign fall = ~dout[0] & edge_d;
endmodule

// File: rtl/tsa_bit_counter.sv
module tsa_bit_counter
  import tsa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  input  logic       fs,
  input  bitpos_t    cfg_start,
  input  bitpos_t    cfg_stop,
  output win_state_t cur,
  output win_state_t nxt
);
  always_comb begin
    nxt = cur;
    if (rise) begin
      if (fs) begin
        nxt.pos   = '0;
        nxt.lo    = cfg_start;
        nxt.hi    = cfg_stop;
        nxt.armed = 1'b1;
      end else begin
        nxt.pos = cur.pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur.pos   <= '0;
      cur.lo    <= '1;
      cur.hi    <= '0;
      cur.armed <= 1'b0;
    end else begin
      cur <= nxt;
    end
  end

  assert_sync_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rise && fs) |=> (cur.pos == '0))
    else $error("R2 position not cleared at frame sync");

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (rise && !fs && cur.pos != '1) |=> (cur.pos == $past(cur.pos) + 1'b1))
    else $error("R2 position did not advance");

  assert_bounds_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(rise && fs) |=> ($stable(cur.lo) && $stable(cur.hi)))
    else $error("R7 bounds changed away from frame sync");
endmodule

// File: rtl/tsa_window_io.sv
module tsa_window_io
  import tsa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  input  logic       fall,
  input  logic       rxd,
  input  logic       tx_bit,
  input  win_state_t cur,
  input  win_state_t nxt,
  output logic       rx_bit,
  output logic       rx_valid,
  output logic       txd,
  output logic       txd_oe,
  output logic       tx_take
);
  logic open_next, open_now;
  assign open_next = in_window(nxt);
  assign open_now  = in_window(cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_bit   <= 1'b0;
      rx_valid <= 1'b0;
      txd      <= 1'b0;
      txd_oe   <= 1'b0;
      tx_take  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_take  <= 1'b0;
      if (rise) begin
        txd_oe  <= open_next;
        txd     <= open_next ? tx_bit : 1'b0;
        tx_take <= open_next;
      end
      if (fall && open_now) begin
        rx_bit   <= rxd;
        rx_valid <= 1'b1;
      end
    end
  end

  assert_take_drives_R6: assert property (@(posedge clk) disable iff (rst)
    tx_take |-> txd_oe)
    else $error("R6 take pulse while transmit released");

  assert_rx_single_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid)
    else $error("R5 receive strobe wider than one cycle");

  assert_take_single_R6: assert property (@(posedge clk) disable iff (rst)
    tx_take |=> !tx_take)
    else $error("R6 take pulse wider than one cycle");

  assert_quiet_released_R6: assert property (@(posedge clk) disable iff (rst)
    !txd_oe |-> !txd)
    else $error("R6 data driven while released");
endmodule

// File: rtl/tdm_slot_assigner.sv
module tdm_slot_assigner
  import tsa_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tdm_bclk,
  input  logic                 tdm_fsync,
  input  logic                 tdm_rxd,
  output logic                 tdm_txd,
  output logic                 tdm_txd_oe,
  input  logic [TSA_POS_W-1:0] cfg_start,
  input  logic [TSA_POS_W-1:0] cfg_stop,
  output logic                 ch_rx_bit,
  output logic                 ch_rx_valid,
  input  logic                 ch_tx_bit,
  output logic                 ch_tx_take
);
  localparam int unsigned BUS_W = 3;

  logic [BUS_W-1:0] bus_s;
  logic             b_rise, b_fall;
  win_state_t       st_cur, st_nxt;

  tsa_edge_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({tdm_rxd, tdm_fsync, tdm_bclk}),
    .dout(bus_s),
    .rise(b_rise),
    .fall(b_fall)
  );

  tsa_bit_counter u_cnt (
    .clk      (clk),
    .rst      (rst),
    .rise     (b_rise),
    .fs       (bus_s[1]),
    .cfg_start(cfg_start),
    .cfg_stop (cfg_stop),
    .cur      (st_cur),
    .nxt      (st_nxt)
  );

  tsa_window_io u_io (
    .clk     (clk),
    .rst     (rst),
    .rise    (b_rise),
    .fall    (b_fall),
    .rxd     (bus_s[2]),
    .tx_bit  (ch_tx_bit),
    .cur     (st_cur),
    .nxt     (st_nxt),
    .rx_bit  (ch_rx_bit),
    .rx_valid(ch_rx_valid),
    .txd     (tdm_txd),
    .txd_oe  (tdm_txd_oe),
    .tx_take (ch_tx_take)
  );

  assert_reversed_closed_R4: assert property (@(posedge clk) disable iff (rst)
    (st_cur.lo > st_cur.hi) |-> (!ch_tx_take && !tdm_txd_oe))
    else $error("R4 window opened with reversed bounds");

  assert_unarmed_closed_R8: assert property (@(posedge clk) disable iff (rst)
    !st_cur.armed |-> (!tdm_txd_oe && !ch_rx_valid))
    else $error("R8 window opened before first frame sync");

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!tdm_txd_oe && !ch_rx_valid && !ch_tx_take))
    else $error("R1 outputs active out of reset");
endmodule

// File: tb/tb_tdm_slot_assigner.sv
module tb_tdm_slot_assigner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tdm_bclk = 1'b0, tdm_fsync = 1'b0, tdm_rxd = 1'b0;
  logic        tdm_txd, tdm_txd_oe;
  logic [11:0] cfg_start = 12'd0, cfg_stop = 12'd0;
  logic        ch_rx_bit, ch_rx_valid, ch_tx_bit, ch_tx_take;

  int unsigned n_chk = 0, n_bad = 0;
  int unsigned take_cnt = 0, rx_cnt = 0;
  logic        rx_last = 1'b0;

  // bench model state
  int unsigned m_pos = 0, m_lo = 4095, m_hi = 0, m_txi = 0;
  bit          m_armed = 1'b0;

  always #2 clk = ~clk;

  function automatic logic txpat(int unsigned k);
    int unsigned h;
    h = k * 32'h9E3779B1;
    return ^(h >> 3);
  endfunction

  assign ch_tx_bit = txpat(take_cnt);

  always @(posedge clk) begin
    if (ch_tx_take) take_cnt <= take_cnt + 1;
    if (ch_rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      rx_last <= ch_rx_bit;
    end
  end

  tdm_slot_assigner dut (
    .clk(clk), .rst(rst),
    .tdm_bclk(tdm_bclk), .tdm_fsync(tdm_fsync), .tdm_rxd(tdm_rxd),
    .tdm_txd(tdm_txd), .tdm_txd_oe(tdm_txd_oe),
    .cfg_start(cfg_start), .cfg_stop(cfg_stop),
    .ch_rx_bit(ch_rx_bit), .ch_rx_valid(ch_rx_valid),
    .ch_tx_bit(ch_tx_bit), .ch_tx_take(ch_tx_take)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (pos %0d)", req, act, exp, m_pos);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit model_open();
    return m_armed && (m_lo <= m_pos) && (m_pos <= m_hi);
  endfunction

  task automatic bus_bit(input bit fs, input string tag);
    logic rd;
    bit   open;
    int unsigned rx_before;
    rd = logic'($urandom % 2);
    tdm_fsync = fs;
    wait_clk(2);
    if (fs) begin
      m_pos = 0; m_armed = 1'b1; m_lo = cfg_start; m_hi = cfg_stop;
    end else begin
      m_pos = (m_pos + 1) % 4096;
    end
    open = model_open();
    tdm_bclk = 1'b1;
    wait_clk(1);
    tdm_rxd = rd;
    wait_clk(5);
    chk(tdm_txd_oe == open, tag, tdm_txd_oe, open);
    if (open) begin
      chk(tdm_txd == txpat(m_txi), "R6", tdm_txd, txpat(m_txi));
      m_txi++;
    end else begin
      chk(tdm_txd == 1'b0, "R6", tdm_txd, 0);
    end
    chk(take_cnt == m_txi, "R6", take_cnt, m_txi);
    rx_before = rx_cnt;
    tdm_bclk = 1'b0;
    wait_clk(6);
    if (open)
      chk(rx_cnt == rx_before + 1 && rx_last == rd, "R5", rx_last, rd);
    else
      chk(rx_cnt == rx_before, "R5", rx_cnt, rx_before);
  endtask

  task automatic frame(input int len, input int lo, input int hi, input string tag,
                       input int chg_at, input int lo2, input int hi2);
    cfg_start = 12'(lo);
    cfg_stop  = 12'(hi);
    for (int i = 0; i < len; i++) begin
      if (i == chg_at && i != 0) begin
        cfg_start = 12'(lo2);
        cfg_stop  = 12'(hi2);
      end
      bus_bit(i == 0, tag);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    wait_clk(4);
    // R1: idle while held in reset
    chk(!tdm_txd_oe && !ch_rx_valid && !ch_tx_take && !tdm_txd, "R1", tdm_txd_oe, 0);
    rst = 1'b0;
    wait_clk(1);
    chk(!tdm_txd_oe && !ch_rx_valid && !ch_tx_take && !tdm_txd, "R1", tdm_txd_oe, 0);

    // R8: bits before any frame sync never open the window
    cfg_start = 12'd0; cfg_stop = 12'd4095;
    for (int i = 0; i < 20; i++) bus_bit(1'b0, "R8");

    // R3 with a mid-frame change (R7), then the new bounds apply (R2 counting)
    frame(32, 3, 10, "R7", 5, 0, 2);
    frame(24, 0, 2, "R3", -1, 0, 0);
    // R4: reversed bounds
    frame(24, 9, 4, "R4", -1, 0, 0);
    // R10: a single bit inside one slot
    frame(24, 13, 13, "R10", -1, 0, 0);
    // R10: three bits of slot 1
    frame(20, 9, 11, "R10", -1, 0, 0);
    // R9: whole frame
    frame(40, 0, 4095, "R9", -1, 0, 0);
    // R9/R2: last position of a 4096-bit frame, then wrap to 0
    frame(4097, 4095, 4095, "R9", -1, 0, 0);
    frame(16, 0, 7, "R2", -1, 0, 0);

    // random windows, some with mid-frame reprogramming
    for (int f = 0; f < 30; f++) begin
      int len, lo, hi, ca;
      len = 8 + int'($urandom % 57);
      lo  = int'($urandom % 70);
      hi  = int'($urandom % 70);
      ca  = ($urandom % 3 == 0) ? 1 + int'($urandom % (len - 1)) : -1;
      frame(len, lo, hi, "R3", ca, int'($urandom % 70), int'($urandom % 70));
    end
    finish_run();
  end
endmodule